// File: doc/BRIEF.md
# Nibble-wide DRAM fetch sequencer

This block reads one screen byte from a DRAM array whose data path is four bits wide and whose address pins carry the row and the column at different times. Every access slot lasts eight clocks. Within a slot the block presents a row address and asserts a row strobe. It then makes two column reads at adjacent column addresses, which differ only in the least significant bit. The first nibble returned becomes the upper half of the byte and the second becomes the lower half. A one-cycle valid pulse delivers the assembled byte, together with a request to advance the screen byte address.

The slot is sequenced by a ring of eight one-hot phases. The ring is the state register, and its decoded phases are the states:
- PH_ROW_SET sets the row address.
- PH_ROW_STB raises the row strobe and sets the even column.
- PH_COL_HI_STB raises the column strobe.
- PH_HI_TAKE captures the high nibble.
- PH_COL_LO_SET drops the column strobe and selects the odd column.
- PH_COL_LO_STB raises the column strobe again.
- PH_LO_TAKE captures the low nibble and pulses valid.
- PH_RELEASE drops both strobes.

Each phase moves unconditionally to the next on every clock, and PH_RELEASE wraps back to PH_ROW_SET. At the start of each slot the block decides whether that slot belongs to video. The decision uses an access counter, the fetch-window enable, a blank input for spacing lines and an NMI inhibit. The counter's modulus follows from the screen mode: every slot is eligible when a line holds 80 bytes, and every second slot when it holds 40.

Top module: `vid_nibble_fetch`

## Requirements
- R1: The phase ring resets with only its last phase set. The first clock edge after reset is released enters PH_ROW_SET, and the eight phases then repeat in order, so a slot lasts exactly 8 clocks.
- R2: In a video slot, `row_addr` equals `byte_addr[14:7]` as sampled at the edge entering PH_ROW_SET. `row_stb` is high throughout phases 1 to 6, and `row_addr` does not change while `row_stb` is high.
- R3: In a video slot, `col_addr` is `{byte_addr[6:0],0}` during phases 1 to 3 and `{byte_addr[6:0],1}` during phases 4 to 6, with the address sampled at the edge entering PH_ROW_STB. `col_stb` is high in phases 2, 3, 5 and 6 only, and only while `row_stb` is high.
- R4: In a video slot, `byte_out` carries the nibble read at the even column in bits [7:4] and the nibble read at the odd column in bits [3:0]. It becomes valid in phase 6, when `byte_vld` and `adv_req` pulse high for exactly one cycle.
- R5: A slot is a video slot only if, at the edge entering PH_ROW_SET, all of the following hold: the access counter is zero, `fetch_win` is 1, `line_blank` is 0 and `nmi_hold` is 0. A slot that is not a video slot raises no strobe and no pulse.
- R6: The access counter advances once per slot, in phase 7, whether or not the slot was used. Its modulus is 80 divided by the bytes per line. Modes 0 to 3 give 80 bytes per line and so make every slot eligible. Modes 4 to 7 give 40 bytes per line and so make only even-numbered slots eligible, counted from the first slot after reset.
- R7: `mode_sel` is sampled only while `rst` is high. A later change of `mode_sel` has no effect on slot eligibility.
- R8: While `rst` is high, `row_stb`, `col_stb`, `byte_vld` and `adv_req` are low and `byte_out`, `row_addr` and `col_addr` are zero.
- R9: Changes on `byte_addr`, `fetch_win`, `line_blank` or `nmi_hold` after the sampling edges of a slot do not alter that slot's strobes, addresses or byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; latches the mode |
| mode_sel | input | 3 | Screen mode, taken during reset |
| byte_addr | input | 15 | Screen byte address to fetch |
| fetch_win | input | 1 | Position lies inside the fetch window |
| line_blank | input | 1 | Spacing line in progress: suppress fetch |
| nmi_hold | input | 1 | NMI inhibit: suppress fetch |
| dram_q | input | 4 | Nibble returned by the DRAM |
| row_addr | output | 8 | Row address to the DRAM |
| col_addr | output | 8 | Column address to the DRAM |
| row_stb | output | 1 | Row strobe, active high |
| col_stb | output | 1 | Column strobe, active high |
| byte_out | output | 8 | Assembled screen byte |
| byte_vld | output | 1 | One-cycle pulse: byte_out is new |
| adv_req | output | 1 | One-cycle request to advance byte_addr |

## Verification
The bench builds the block with its default parameters: a 15-bit byte address split at bit 7, 4-bit nibbles and an 80-byte full line. With these values the bench's nibble store covers the complete 65536-entry row and column space, so the extreme addresses 0x0000 and 0x7FFF are reachable. All eight mode codes are swept, which exercises both counter moduli, and the mode input is flipped after reset in every sweep. Every cycle of 24 slots per mode is compared against phase-by-phase expectations. These are derived from the slot count, from patterned enables and from addresses that are deliberately disturbed mid-slot.

// File: rtl/vnf_pkg.sv
package vnf_pkg;

    localparam int PHASES = 8;

    typedef enum logic [2:0] {
        PH_ROW_SET    = 3'd0,
        PH_ROW_STB    = 3'd1,
        PH_COL_HI_STB = 3'd2,
        PH_HI_TAKE    = 3'd3,
        PH_COL_LO_SET = 3'd4,
        PH_COL_LO_STB = 3'd5,
        PH_LO_TAKE    = 3'd6,
        PH_RELEASE    = 3'd7
    } phase_t;

    // Bytes fetched per line for each mode: pixels across times bits per pixel, over 8.
    function automatic int unsigned line_bytes(input logic [2:0] mode);
        int unsigned px;
        int unsigned bpp;
        unique case (mode)
            3'd0:    begin px = 640; bpp = 1; end
            3'd1:    begin px = 320; bpp = 2; end
            3'd2:    begin px = 160; bpp = 4; end
            3'd3:    begin px = 640; bpp = 1; end
            3'd4:    begin px = 320; bpp = 1; end
            3'd5:    begin px = 160; bpp = 2; end
            default: begin px = 320; bpp = 1; end
        endcase
        return (px * bpp) / 8;
    endfunction

    // Slots per video access.
    function automatic int unsigned slot_divisor(input logic [2:0] mode, input int unsigned full_line);
        return full_line / line_bytes(mode);
    endfunction

endpackage

// File: rtl/vnf_phase_ring.sv
module vnf_phase_ring
    import vnf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t cur_ph,
    output phase_t nxt_ph
);

    logic [PHASES-1:0] ring_q;
    logic [PHASES-1:0] ring_d;

    function automatic phase_t decode(input logic [PHASES-1:0] oh);
        phase_t p;
        p = PH_ROW_SET;
        for (int i = 0; i < PHASES; i++) begin
            if (oh[i]) p = phase_t'(i);
        end
        return p;
    endfunction

    assign ring_d = {ring_q[PHASES-2:0], ring_q[PHASES-1]};

    always_ff @(posedge clk) begin
        if (rst) ring_q <= {1'b1, {(PHASES-1){1'b0}}};
        else     ring_q <= ring_d;
    end

    always_comb begin
        cur_ph = decode(ring_q);
        nxt_ph = decode(ring_d);
    end

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(ring_q)) else $error("ring not one-hot"); // R1

    AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
        ring_q[PHASES-1] |=> ring_q[0]) else $error("ring did not wrap"); // R1

endmodule

// File: rtl/vnf_slot_gate.sv
module vnf_slot_gate
    import vnf_pkg::*;
#(
    parameter int ACC_W     = 2,
    parameter int FULL_LINE = 80
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  phase_t     nxt_ph,
    input  logic       fetch_win,
    input  logic       line_blank,
    input  logic       nmi_hold,
    output logic       use_now,
    output logic       slot_use
);

    logic [ACC_W-1:0] div_q;
    logic [ACC_W-1:0] acc_q;

    assign use_now = (acc_q == '0) && fetch_win && !line_blank && !nmi_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= ACC_W'(slot_divisor(mode_sel, FULL_LINE));
            acc_q    <= '0;
            slot_use <= 1'b0;
        end else begin
            unique case (nxt_ph)
                PH_ROW_SET: slot_use <= use_now;
                PH_RELEASE: acc_q <= (acc_q == div_q - 1'b1) ? '0 : acc_q + 1'b1;
                default: ;
            endcase
        end
    end

    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
        acc_q < div_q) else $error("access counter out of range"); // R6

    AST_USE_HELD: assert property (@(posedge clk) disable iff (rst)
        (nxt_ph != PH_ROW_SET) |=> $stable(slot_use)) else $error("slot decision moved mid-slot"); // R9

endmodule

// File: rtl/vnf_dram_seq.sv
module vnf_dram_seq
    import vnf_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int COL_BITS = 7,
    parameter int NIB_W    = 4,
    localparam int RW      = ADDR_W - COL_BITS,
    localparam int CW      = COL_BITS + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            cur_ph,
    input  phase_t            nxt_ph,
    input  logic              use_now,
    input  logic              slot_use,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [NIB_W-1:0]  dram_q,
    output logic [RW-1:0]     row_addr,
    output logic [CW-1:0]     col_addr,
    output logic              row_stb,
    output logic              col_stb,
    output logic [2*NIB_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              adv_req
);

    logic [NIB_W-1:0] hi_nib;

    // Outputs follow the phase being entered at each edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            row_addr <= '0;
            col_addr <= '0;
            row_stb  <= 1'b0;
            col_stb  <= 1'b0;
            hi_nib   <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
            adv_req  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            adv_req  <= 1'b0;
            unique case (nxt_ph)
                PH_ROW_SET: begin
                    if (use_now) row_addr <= byte_addr[ADDR_W-1:COL_BITS];
                end
                PH_ROW_STB: begin
                    if (slot_use) begin
                        row_stb  <= 1'b1;
                        col_addr <= {byte_addr[COL_BITS-1:0], 1'b0};
                    end
                end
                PH_COL_HI_STB: begin
                    if (slot_use) col_stb <= 1'b1;
                end
                PH_HI_TAKE: begin
                    if (slot_use) hi_nib <= dram_q;
                end
                PH_COL_LO_SET: begin
                    col_stb <= 1'b0;
                    if (slot_use) col_addr[0] <= 1'b1;
                end
                PH_COL_LO_STB: begin
                    if (slot_use) col_stb <= 1'b1;
                end
                PH_LO_TAKE: begin
                    if (slot_use) begin
                        byte_out <= {hi_nib, dram_q};
                        byte_vld <= 1'b1;
                        adv_req  <= 1'b1;
                    end
                end
                PH_RELEASE: begin
                    col_stb <= 1'b0;
                    row_stb <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    AST_VLD_IN_LO_TAKE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> (cur_ph == PH_LO_TAKE)) else $error("valid outside phase 6"); // R4

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld) else $error("valid longer than one cycle"); // R4

    AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        col_stb |-> row_stb) else $error("column strobe without row"); // R3

    AST_ROW_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        row_stb |-> $stable(row_addr)) else $error("row address moved under strobe"); // R2

    AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (rst)
        !slot_use |-> !row_stb) else $error("strobe in unused slot"); // R5

endmodule

// File: rtl/vid_nibble_fetch.sv
module vid_nibble_fetch
    import vnf_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int COL_BITS  = 7,
    parameter int NIB_W     = 4,
    parameter int FULL_LINE = 80,
    parameter int ACC_W     = 2,
    localparam int RW       = ADDR_W - COL_BITS,
    localparam int CW       = COL_BITS + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         mode_sel,
    input  logic [ADDR_W-1:0]  byte_addr,
    input  logic               fetch_win,
    input  logic               line_blank,
    input  logic               nmi_hold,
    input  logic [NIB_W-1:0]   dram_q,
    output logic [RW-1:0]      row_addr,
    output logic [CW-1:0]      col_addr,
    output logic               row_stb,
    output logic               col_stb,
    output logic [2*NIB_W-1:0] byte_out,
    output logic               byte_vld,
    output logic               adv_req
);

    phase_t cur_ph;
    phase_t nxt_ph;
    logic   use_now;
    logic   slot_use;

    vnf_phase_ring u_ring (
        .clk    (clk),
        .rst    (rst),
        .cur_ph (cur_ph),
        .nxt_ph (nxt_ph)
    );

    vnf_slot_gate #(
        .ACC_W     (ACC_W),
        .FULL_LINE (FULL_LINE)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .nxt_ph     (nxt_ph),
        .fetch_win  (fetch_win),
        .line_blank (line_blank),
        .nmi_hold   (nmi_hold),
        .use_now    (use_now),
        .slot_use   (slot_use)
    );

    vnf_dram_seq #(
        .ADDR_W   (ADDR_W),
        .COL_BITS (COL_BITS),
        .NIB_W    (NIB_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cur_ph    (cur_ph),
        .nxt_ph    (nxt_ph),
        .use_now   (use_now),
        .slot_use  (slot_use),
        .byte_addr (byte_addr),
        .dram_q    (dram_q),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .row_stb   (row_stb),
        .col_stb   (col_stb),
        .byte_out  (byte_out),
        .byte_vld  (byte_vld),
        .adv_req   (adv_req)
    );

endmodule

// File: tb/vid_nibble_fetch_tb_top.sv
`timescale 1ns/1ps
module vid_nibble_fetch_tb_top;

    localparam int NSLOT = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_sel = 3'd0;
    logic [14:0] byte_addr = '0;
    logic        fetch_win = 1'b0;
    logic        line_blank = 1'b0;
    logic        nmi_hold = 1'b0;
    logic [3:0]  dram_q;
    logic [7:0]  row_addr;
    logic [7:0]  col_addr;
    logic        row_stb;
    logic        col_stb;
    logic [7:0]  byte_out;
    logic        byte_vld;
    logic        adv_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vid_nibble_fetch dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .byte_addr(byte_addr),
        .fetch_win(fetch_win), .line_blank(line_blank), .nmi_hold(nmi_hold),
        .dram_q(dram_q), .row_addr(row_addr), .col_addr(col_addr),
        .row_stb(row_stb), .col_stb(col_stb), .byte_out(byte_out),
        .byte_vld(byte_vld), .adv_req(adv_req)
    );

    // DRAM model: 65536 nibbles addressed by {row, column}.
    logic [3:0] mem [0:65535];
    logic [7:0] row_lat = '0;
    logic       ras_seen = 1'b0;

    function automatic logic [3:0] nib_of(input int idx);
        return 4'(((idx * 13) ^ (idx >> 5) ^ (idx >> 11)) & 15);
    endfunction

    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = nib_of(i);
    end

    always @(negedge clk) begin
        ras_seen <= row_stb;
        if (row_stb && !ras_seen) row_lat <= row_addr;
    end

    assign dram_q = col_stb ? mem[{row_lat, col_addr}] : 4'h0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [14:0] slot_addr(input int s, input int m);
        if (s == 0) return 15'h7FFF;
        if (s == 1) return 15'h0000;
        return 15'((s * 32'h123 + m * 32'h1111 + 32'h7F) & 32'h7FFF);
    endfunction

    logic        use_cur;
    logic        ctr_ok;
    logic [14:0] addr_cur;

    task automatic drive_slot(input int s, input int m);
        int div;
        div        = (m < 4) ? 1 : 2;
        addr_cur   = slot_addr(s, m);
        byte_addr  = addr_cur;
        fetch_win  = (((s * 5 + m) % 7) != 0);
        line_blank = ((s % 6) == 3);
        nmi_hold   = ((s % 9) == 5);
        ctr_ok     = ((s % div) == 0);
        use_cur    = ctr_ok && fetch_win && !line_blank && !nmi_hold;
    endtask

    task automatic run_mode(input int m);
        rst = 1'b1;
        mode_sel = 3'(m);
        repeat (3) @(negedge clk);
        check("R8 row_stb in reset", int'(row_stb), 0);
        check("R8 col_stb in reset", int'(col_stb), 0);
        check("R8 byte_vld in reset", int'(byte_vld), 0);
        check("R8 adv_req in reset", int'(adv_req), 0);
        check("R8 byte_out in reset", int'(byte_out), 0);
        check("R8 addresses in reset", int'({row_addr, col_addr}), 0);
        rst = 1'b0;
        drive_slot(0, m);
        for (int n = 1; n <= NSLOT * 8; n++) begin
            int ph;
            int s;
            bit ras_e;
            bit cas_e;
            bit vld_e;
            string tag;
            @(negedge clk);
            ph = (n - 1) % 8;
            s  = (n - 1) / 8;
            ras_e = use_cur && (ph >= 1) && (ph <= 6);
            cas_e = use_cur && (ph == 2 || ph == 3 || ph == 5 || ph == 6);
            vld_e = use_cur && (ph == 6);
            if (!ctr_ok)       tag = "R6/R7";
            else if (!use_cur) tag = "R5";
            else if (s == 0)   tag = "R1";
            else               tag = "R2";
            check({tag, " row_stb"}, int'(row_stb), int'(ras_e));
            check({(use_cur ? "R3" : tag), " col_stb"}, int'(col_stb), int'(cas_e));
            check({(use_cur ? "R4" : tag), " byte_vld"}, int'(byte_vld), int'(vld_e));
            check({(use_cur ? "R4" : tag), " adv_req"}, int'(adv_req), int'(vld_e));
            if (ras_e) begin
                check("R2 row_addr", int'(row_addr), int'(addr_cur[14:7]));
                if (ph <= 3) check("R3 col_addr even", int'(col_addr), int'({addr_cur[6:0], 1'b0}));
                else         check("R3/R9 col_addr odd", int'(col_addr), int'({addr_cur[6:0], 1'b1}));
            end
            if (vld_e) begin
                check("R4/R9 byte_out", int'(byte_out),
                      int'({nib_of(int'({addr_cur, 1'b0})), nib_of(int'({addr_cur, 1'b1}))}));
            end
            if (ph == 3) begin
                // Disturb sampled inputs mid-slot; the mode input is flipped too.
                byte_addr  = ~byte_addr;
                fetch_win  = ~fetch_win;
                line_blank = ~line_blank;
                nmi_hold   = ~nmi_hold;
                mode_sel   = 3'(m) ^ 3'd4;
            end
            if (ph == 7) drive_slot(s + 1, m);
        end
    endtask

    initial begin
        for (int m = 0; m < 8; m++) run_mode(m);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule